// File: doc/BRIEF.md
# DMA Channel Control/Status and Interrupt Bank

This block holds one 32-bit control/status word for each DMA channel. Software reads and writes these words over a simple word-wide register bus. The channel engines report their events as single-cycle pulses. The block folds those events into the status bits and gives each engine its run and mode controls back. The request router supplies a per-channel request-pending level, which shows up in the read data.

Each channel can raise five interrupt causes: start, end, stop, end-of-receive and request-asserted. The start and end causes always count. The stop, end-of-receive and request-asserted causes count only while their enable bit is set. The causes of all channels are combined into a summary word with one bit per channel. A single registered interrupt line goes high whenever any summary bit is set. Channel words sit at bus word addresses 0 to NCH-1. The summary word sits at address 2**clog2(NCH), which is address 32 with the default of 32 channels.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every channel word reads 0x0000_0008, with only the stop status (bit 3) set. The summary reads 0, irq_o is low and all per-channel control outputs are 0.
- R2: On a write, a 1 in bit 0 (bus error), bit 1 (start), bit 2 (end) or bit 9 (end-of-receive) clears that status bit. The status bits at 0–4, 9 and 10 are otherwise kept, including bit 4 (request-asserted) when a 1 is written to it.
- R3: A write loads control bits 23 (request-asserted irq enable), 26 (eor stop enable), 27 (eor jump enable), 28 (eor irq enable), 29 (stop irq enable), 30 (no-descriptor-fetch) and 31 (run) from the written data. Bits 22 (mask-run), 24 and 25 are never stored and always read 0.
- R4: A write with bit 31 set clears the stop status, and run_o for that channel goes high on the next cycle.
- R5: A write with bits 31 and 22 both 0 sets the stop status. A write that sets bit 29 clears the stop status, unless the first rule then sets it again. A write with only mask-run set leaves the stop status as it was.
- R6: Write strobe bit 24 clears the compare status (bit 10) and strobe bit 25 sets it. When both are written, the set wins.
- R7: An event pulse sets its status bit on the next clock: error→0, start→1, end→2, stop→3, request-asserted→4, end-of-receive→9, compare→10.
- R8: When an event pulse and a software write that would clear the same bit arrive in the same cycle, the bit ends up set.
- R9: The stop, end-of-receive and request-asserted causes are active only while enable bits 29, 28 and 23 are set, respectively. The start and end status bits are causes with no enable.
- R10: Summary bit c is the OR of channel c's five causes. irq_o is high one clock after any summary bit becomes set, and low one clock after all summary bits clear.
- R11: A channel read returns bit 8 as 1 while that channel's req_pend_i bit is high, and as 0 otherwise.
- R12: run_o, nofetch_o, eor_stop_o and eor_jump_o carry each channel's stored bits 31, 30, 26 and 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | clog2(NCH)+1 | Word address: channels, then summary |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| ev_err_i | input | NCH | Bus-error event pulse per channel |
| ev_start_i | input | NCH | Start event pulse per channel |
| ev_end_i | input | NCH | End event pulse per channel |
| ev_stop_i | input | NCH | Stop event pulse per channel |
| ev_eor_i | input | NCH | End-of-receive event pulse per channel |
| ev_ras_i | input | NCH | Request-asserted event pulse per channel |
| ev_cmp_i | input | NCH | Compare event pulse per channel |
| req_pend_i | input | NCH | Request-pending level per channel |
| run_o | output | NCH | Run control per channel |
| nofetch_o | output | NCH | No-descriptor-fetch mode per channel |
| eor_stop_o | output | NCH | Stop-on-end-of-receive enable per channel |
| eor_jump_o | output | NCH | Jump-on-end-of-receive enable per channel |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The embedded assertions watch a set of rules on every cycle:
- a run write clears the stop status;
- an idle write (neither run nor mask-run) sets it;
- a write-one-to-clear of the end bit takes effect when no event competes;
- start and end-of-receive pulses always leave their bit set, even against a clearing write;
- a pending start status forces the interrupt high;
- the line stays low when no ungated cause and no enable exist anywhere.

The bench's scenarios show the rest:
- exact read-back values after mixed writes;
- the set/clear order of the compare strobes;
- gating of stop and request-asserted causes by their enables;
- the one-cycle interrupt latency;
- merging of request-pending into bit 8;
- the summary pattern across several channels.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int B_ERR     = 0;
  localparam int B_START   = 1;
  localparam int B_END     = 2;
  localparam int B_STOP    = 3;
  localparam int B_RAS     = 4;
  localparam int B_REQ     = 8;
  localparam int B_EOR     = 9;
  localparam int B_CMP     = 10;
  localparam int B_MASK    = 22;
  localparam int B_RASEN   = 23;
  localparam int B_CCLR    = 24;
  localparam int B_CSET    = 25;
  localparam int B_EORSTOP = 26;
  localparam int B_EORJMP  = 27;
  localparam int B_EOREN   = 28;
  localparam int B_STOPEN  = 29;
  localparam int B_NOFETCH = 30;
  localparam int B_RUN     = 31;

  localparam logic [31:0] KEEP_MASK = 32'h0000_061f;
  localparam logic [31:0] W1C_MASK  = 32'h0000_0207;
  localparam logic [31:0] CTRL_MASK = 32'hfc80_0000;
  localparam logic [31:0] RST_WORD  = 32'h0000_0008;

  typedef struct packed {
    logic err;
    logic start;
    logic done;
    logic stop;
    logic eor;
    logic ras;
    logic cmp;
  } chan_ev_t;
endpackage

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dma_csr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  chan_ev_t    ev_i,
  output logic [31:0] csr_o
);
  logic [31:0] csr_q, csr_d;

  always_comb begin
    csr_d = csr_q;
    if (wr_i) begin
      csr_d = (csr_q & KEEP_MASK) & ~(wdata_i & W1C_MASK);
      csr_d = csr_d | (wdata_i & CTRL_MASK);
      if (csr_d[B_STOPEN]) csr_d[B_STOP] = 1'b0;
      if (wdata_i[B_RUN]) csr_d[B_STOP] = 1'b0;
      if (!wdata_i[B_RUN] && !wdata_i[B_MASK]) csr_d[B_STOP] = 1'b1;
      if (wdata_i[B_CCLR]) csr_d[B_CMP] = 1'b0;
      if (wdata_i[B_CSET]) csr_d[B_CMP] = 1'b1;
    end
    // engine events override any same-cycle software clear
    if (ev_i.err)   csr_d[B_ERR]   = 1'b1;
    if (ev_i.start) csr_d[B_START] = 1'b1;
    if (ev_i.done)  csr_d[B_END]   = 1'b1;
    if (ev_i.stop)  csr_d[B_STOP]  = 1'b1;
    if (ev_i.ras)   csr_d[B_RAS]   = 1'b1;
    if (ev_i.eor)   csr_d[B_EOR]   = 1'b1;
    if (ev_i.cmp)   csr_d[B_CMP]   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) csr_q <= RST_WORD;
    else         csr_q <= csr_d;
  end

  assign csr_o = csr_q;

  assert_run_clears_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_RUN] && !ev_i.stop) |=> (csr_o[B_RUN] && !csr_o[B_STOP]));

  assert_idle_sets_stop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[B_RUN] && !wdata_i[B_MASK]) |=> csr_o[B_STOP]);

  assert_w1c_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_END] && !ev_i.done) |=> !csr_o[B_END]);

  assert_start_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.start |=> csr_o[B_START]);

  assert_eor_event_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.eor |=> csr_o[B_EOR]);
endmodule

// File: rtl/dma_irq_combine.sv
module dma_irq_combine
  import dma_csr_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NCH-1:0][31:0] csr_i,
  output logic [31:0]          summary_o,
  output logic                 irq_o
);
  logic [NCH-1:0] cause_v, ungated_v, enable_v;
  logic           irq_q;

  for (genvar c = 0; c < NCH; c++) begin : g_cause
    logic stop_c, eor_c, ras_c;
    assign stop_c       = csr_i[c][B_STOP] & csr_i[c][B_STOPEN];
    assign eor_c        = csr_i[c][B_EOR]  & csr_i[c][B_EOREN];
    assign ras_c        = csr_i[c][B_RAS]  & csr_i[c][B_RASEN];
    assign ungated_v[c] = csr_i[c][B_START] | csr_i[c][B_END];
    assign enable_v[c]  = csr_i[c][B_STOPEN] | csr_i[c][B_EOREN] | csr_i[c][B_RASEN];
    assign cause_v[c]   = stop_c | eor_c | ras_c | ungated_v[c];
  end

  always_comb begin
    summary_o = '0;
    summary_o[NCH-1:0] = cause_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |cause_v;
  end

  assign irq_o = irq_q;

  assert_ungated_raises_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ungated_v) |=> irq_o);

  assert_quiet_keeps_irq_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|ungated_v) && !(|enable_v)) |=> !irq_o);
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NCH = 32,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NCH-1:0]    ev_err_i,
  input  logic [NCH-1:0]    ev_start_i,
  input  logic [NCH-1:0]    ev_end_i,
  input  logic [NCH-1:0]    ev_stop_i,
  input  logic [NCH-1:0]    ev_eor_i,
  input  logic [NCH-1:0]    ev_ras_i,
  input  logic [NCH-1:0]    ev_cmp_i,
  input  logic [NCH-1:0]    req_pend_i,
  output logic [NCH-1:0]    run_o,
  output logic [NCH-1:0]    nofetch_o,
  output logic [NCH-1:0]    eor_stop_o,
  output logic [NCH-1:0]    eor_jump_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] SUM_ADDR = ADDR_W'(1 << CH_W);

  logic [NCH-1:0][31:0] csr_w;
  logic [31:0]          summary_w;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    chan_ev_t ev_c;
    logic     sel_c;
    assign sel_c = wr_i && (addr_i == ADDR_W'(c));
    assign ev_c  = '{err: ev_err_i[c], start: ev_start_i[c], done: ev_end_i[c],
                     stop: ev_stop_i[c], eor: ev_eor_i[c], ras: ev_ras_i[c],
                     cmp: ev_cmp_i[c]};

    dma_chan_csr u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (sel_c),
      .wdata_i (wdata_i),
      .ev_i    (ev_c),
      .csr_o   (csr_w[c])
    );

    assign run_o[c]      = csr_w[c][B_RUN];
    assign nofetch_o[c]  = csr_w[c][B_NOFETCH];
    assign eor_stop_o[c] = csr_w[c][B_EORSTOP];
    assign eor_jump_o[c] = csr_w[c][B_EORJMP];
  end

  dma_irq_combine #(.NCH(NCH)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .csr_i     (csr_w),
    .summary_o (summary_w),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == SUM_ADDR) rdata_o = summary_w;
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == ADDR_W'(c)) begin
        rdata_o = csr_w[c];
        rdata_o[B_REQ] = req_pend_i[c];
      end
    end
  end
endmodule

// File: tb/tb_dma_csr_bank.sv
module tb_dma_csr_bank;
  localparam int NCH = 32;
  localparam int AW  = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NCH-1:0]  ev_err = '0, ev_start = '0, ev_end = '0, ev_stop = '0;
  logic [NCH-1:0]  ev_eor = '0, ev_ras = '0, ev_cmp = '0, req_pend = '0;
  logic [NCH-1:0]  run, nofetch, eor_stop, eor_jump;
  logic            irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  dma_csr_bank #(.NCH(NCH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ev_err_i(ev_err), .ev_start_i(ev_start), .ev_end_i(ev_end),
    .ev_stop_i(ev_stop), .ev_eor_i(ev_eor), .ev_ras_i(ev_ras), .ev_cmp_i(ev_cmp),
    .req_pend_i(req_pend), .run_o(run), .nofetch_o(nofetch),
    .eor_stop_o(eor_stop), .eor_jump_o(eor_jump), .irq_o(irq)
  );

  // monitor: pops expected items and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          0: act = rdata;
          1: act = {31'b0, irq};
          2: act = run;
          3: act = nofetch;
          4: act = eor_stop;
          default: act = eor_jump;
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(int kind, int a, logic [31:0] e, string tag);
    item_t it;
    addr = AW'(a);
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
  endtask

  // one bus/event cycle; ev_kind: 0 err,1 start,2 end,3 stop,4 eor,5 ras,6 cmp
  task automatic cycle(bit do_wr, int ch, logic [31:0] d, int ev_kind, int ev_ch);
    @(posedge clk); #1;
    wr = do_wr; addr = AW'(ch); wdata = d;
    case (ev_kind)
      0: ev_err[ev_ch] = 1'b1;
      1: ev_start[ev_ch] = 1'b1;
      2: ev_end[ev_ch] = 1'b1;
      3: ev_stop[ev_ch] = 1'b1;
      4: ev_eor[ev_ch] = 1'b1;
      5: ev_ras[ev_ch] = 1'b1;
      6: ev_cmp[ev_ch] = 1'b1;
      default: ;
    endcase
    @(posedge clk); #1;
    wr = 1'b0; ev_err = '0; ev_start = '0; ev_end = '0; ev_stop = '0;
    ev_eor = '0; ev_ras = '0; ev_cmp = '0;
  endtask

  task automatic wr_reg(int ch, logic [31:0] d);
    cycle(1'b1, ch, d, -1, 0);
  endtask

  task automatic pulse(int ev_kind, int ch);
    cycle(1'b0, 0, 32'h0, ev_kind, ch);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    expect_val(0, 0, 32'h0000_0008, "R1 ch0 reset");
    expect_val(0, 31, 32'h0000_0008, "R1 ch31 reset");
    expect_val(0, 32, 32'h0, "R1 summary reset");
    expect_val(1, 0, 32'h0, "R1 irq reset");
    expect_val(2, 0, 32'h0, "R1 run reset");

    // R3 R6 all-ones write: controls loaded, set strobe wins
    wr_reg(0, 32'hffff_ffff);
    expect_val(0, 0, 32'hfc80_0400, "R3 R6 ch0 all ones");
    expect_val(2, 0, 32'h1, "R12 run ch0");
    expect_val(3, 0, 32'h1, "R12 nofetch ch0");
    // R5 idle write sets stop, compare kept
    wr_reg(0, 32'h0);
    expect_val(0, 0, 32'h0000_0408, "R5 ch0 idle write");
    // R4 run clears stop
    wr_reg(0, 32'h8000_0000);
    expect_val(0, 0, 32'h8000_0400, "R4 ch0 run");
    expect_val(2, 0, 32'h1, "R4 run_o");
    // R5 mask-run alone keeps stop clear
    wr_reg(0, 32'h0040_0000);
    expect_val(0, 0, 32'h0000_0400, "R5 ch0 mask only");
    // R6 clear strobe
    wr_reg(0, 32'h0100_0000);
    expect_val(0, 0, 32'h0000_0008, "R6 ch0 cmp clear");

    // R9 R10 stop cause gated by enable, irq one cycle late
    wr_reg(0, 32'h2000_0000);
    expect_val(1, 0, 32'h0, "R10 irq latency");
    expect_val(1, 0, 32'h1, "R10 irq raised");
    expect_val(0, 0, 32'h2000_0008, "R5 stopen then idle sets stop");
    expect_val(0, 32, 32'h1, "R9 stop cause summary");
    wr_reg(0, 32'h2040_0000);
    expect_val(0, 0, 32'h2000_0000, "R5 stopen clears stop");
    expect_val(0, 32, 32'h0, "R9 stop cause gone");
    expect_val(1, 0, 32'h0, "R10 irq dropped");

    // R7 R9 start event, ungated
    pulse(1, 1);
    expect_val(0, 1, 32'h0000_000a, "R7 start ch1");
    expect_val(0, 32, 32'h2, "R9 start ungated");
    expect_val(1, 0, 32'h1, "R10 irq start");
    wr_reg(1, 32'h0040_0002);
    expect_val(0, 1, 32'h0000_0008, "R2 start w1c");
    expect_val(0, 32, 32'h0, "R2 summary cleared");

    // R9 request-asserted gated
    pulse(5, 2);
    expect_val(0, 2, 32'h0000_0018, "R7 ras ch2");
    expect_val(0, 32, 32'h0, "R9 ras gated off");
    wr_reg(2, 32'h0080_0000);
    expect_val(0, 2, 32'h0080_0018, "R3 rasen load");
    expect_val(0, 32, 32'h4, "R9 ras enabled");
    wr_reg(2, 32'h0080_0010);
    expect_val(0, 2, 32'h0080_0018, "R2 ras not w1c");

    // R8 event beats same-cycle clear
    cycle(1'b1, 3, 32'h0000_0200, 4, 3);
    expect_val(0, 3, 32'h0000_0208, "R8 eor event wins");
    wr_reg(3, 32'h0000_0200);
    expect_val(0, 3, 32'h0000_0008, "R2 eor w1c");

    // R11 request pending merge
    req_pend[3] = 1'b1;
    expect_val(0, 3, 32'h0000_0108, "R11 req pending high");
    req_pend[3] = 1'b0;
    expect_val(0, 3, 32'h0000_0008, "R11 req pending low");

    // R7 error and end events, R2 clear both
    pulse(0, 1);
    pulse(2, 1);
    expect_val(0, 1, 32'h0000_000d, "R7 err end ch1");
    expect_val(0, 32, 32'h6, "R10 summary two channels");
    wr_reg(1, 32'h0000_0005);
    expect_val(0, 1, 32'h0000_0008, "R2 err end w1c");
    cycle(1'b1, 1, 32'h0100_0000, 6, 1);
    expect_val(0, 1, 32'h0000_0408, "R8 cmp event beats clear strobe");

    // R7 stop event on running channel
    wr_reg(0, 32'h8000_0000);
    expect_val(0, 0, 32'h8000_0000, "R4 ch0 running");
    pulse(3, 0);
    expect_val(0, 0, 32'h8000_0008, "R7 stop event");

    // R12 mode outputs
    wr_reg(2, 32'hc800_0000);
    expect_val(0, 2, 32'hc800_0010, "R3 ch2 modes");
    expect_val(2, 0, 32'h0000_0005, "R12 run vector");
    expect_val(3, 0, 32'h0000_0004, "R12 nofetch vector");
    expect_val(4, 0, 32'h0000_0000, "R12 eor stop vector");
    expect_val(5, 0, 32'h0000_0004, "R12 eor jump vector");
    expect_val(0, 32, 32'h0, "R10 summary idle");

    // R10 multi-channel summary
    pulse(1, 0);
    pulse(1, 3);
    expect_val(0, 32, 32'h9, "R10 summary ch0 ch3");
    expect_val(1, 0, 32'h1, "R10 irq multi");

    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule